// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the architectural side of taking a trap. A one-cycle request strobe arrives with a 9-bit trap type and a snapshot of the processor: program counter, next program counter, status word, the window pointer and the count of windows that can still be saved. The sequencer then raises the trap level and pushes the old pc, npc, status word and trap type onto a small per-level trap stack. It builds the new status word for the handler and turns the window pointer when the trap is a window trap. Finally it forms the handler address from a trap base register, or from the hypervisor trap base when the hypervisor flag is set.

Every update lands on the clock edge that samples the request. A `done` pulse marks the following cycle, in which the new pc and npc are valid. A request that arrives when the trap level has already reached the limit on `maxLevel` does not enter the trap. It moves the block into a sticky error state instead, and only reset clears that state. The trap stack can be read at any time through a combinational read port indexed by level.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset `trapLevel` is 0, `errState` is 0, `done` is 0 and `pcOut`, `npcOut`, `statusOut` and `cwpOut` are 0.
- R2: A request that arrives while `trapLevel >= maxLevel` sets `errState` and leaves `pcOut`, `npcOut`, `statusOut`, `cwpOut`, `trapLevel` and `done` unchanged. `errState` stays set until reset, and any later request has no effect on those outputs.
- R3: An accepted request increments `trapLevel` by one. When the old level equals `maxLevel - 1`, the new status word also has its red-state bit (bit 5) set.
- R4: After an accepted request, the trap-stack entry at the new level, read through `rdIdx`, returns the `pcIn`, `npcIn`, `statusIn` and `trapType` that were sampled with that request.
- R5: For trap types 0x064 to 0x06F (the translation miss and protection groups), the new status word is PRIV (bit 3) | FPEN (bit 4) | MMUG (bit 1). For every other type it is PRIV | FPEN | ALTG (bit 0). All other bits are zero, apart from red-state per R3.
- R6: For type 0x024, `cwpOut` is `cwpIn - 1`. For types with `(type & 0x1C0) == 0x080` it is `cwpIn - cansaveIn - 2`. For types with `(type & 0x1C0) == 0x0C0` it is `cwpIn + 1`. All of these wrap modulo `nWin`. For any other type `cwpOut` equals `cwpIn`.
- R7: With `hyperMode` low, `pcOut` is built from three parts: `tbaIn` with bits [14:0] cleared, bit 14 set when the new trap level is greater than 1, and `trapType << 5`.
- R8: With `hyperMode` high, `pcOut` is `htbaIn` with bits [13:0] cleared, ORed with `trapType << 5`.
- R9: `npcOut` equals `pcOut + 4` after every accepted request.
- R10: `done` is high for exactly the one cycle after an accepted request, and it is never high after a rejected one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | One-cycle trap request strobe |
| trapType | input | 9 | Trap type code |
| pcIn | input | ADDR_W | Program counter at the trap |
| npcIn | input | ADDR_W | Next program counter at the trap |
| statusIn | input | STAT_W | Status word at the trap |
| tbaIn | input | ADDR_W | Trap base register |
| htbaIn | input | ADDR_W | Hypervisor trap base register |
| maxLevel | input | TL_W | Highest permitted trap level |
| cwpIn | input | WIN_W | Current window pointer |
| cansaveIn | input | WIN_W | Count of saveable windows |
| nWin | input | WIN_W | Number of register windows |
| hyperMode | input | 1 | Selects hypervisor vector base |
| rdIdx | input | TL_W | Trap-stack read index |
| pcOut | output | ADDR_W | New program counter |
| npcOut | output | ADDR_W | New next program counter |
| statusOut | output | STAT_W | New status word |
| cwpOut | output | WIN_W | New window pointer |
| trapLevel | output | TL_W | Current trap level |
| errState | output | 1 | Sticky error state |
| done | output | 1 | New pc/npc valid this cycle |
| rdPc | output | ADDR_W | Saved pc at `rdIdx` |
| rdNpc | output | ADDR_W | Saved npc at `rdIdx` |
| rdStatus | output | STAT_W | Saved status at `rdIdx` |
| rdType | output | 9 | Saved trap type at `rdIdx` |

## Verification
The bench pushes each run of traps up to and past `maxLevel`. A design that set red-state one level early or one level late, or that still entered the trap at the limit, would show the wrong status word, a stray `done` or a moved pc. Window traps are driven with a window pointer of 0, with one at `nWin - 1` and with a large `cansaveIn`, so that any arithmetic that forgets to wrap modulo `nWin` returns an out-of-range pointer. Vector generation is tried in both base modes with base bit 14 set, so that a mask applied the wrong way round, or a nested-level bit tied to the wrong level, would show up in `pcOut`.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int TT_W   = 9;
  localparam int ALTG_B = 0;
  localparam int MMUG_B = 1;
  localparam int PRIV_B = 3;
  localparam int FPEN_B = 4;
  localparam int RED_B  = 5;

  typedef enum logic [1:0] {
    WIN_KEEP  = 2'd0,
    WIN_CLEAN = 2'd1,
    WIN_SPILL = 2'd2,
    WIN_FILL  = 2'd3
  } win_op_e;

  typedef struct packed {
    logic    commit;
    logic    setRed;
    logic    mmuGrp;
    logic    nested;
    win_op_e winOp;
  } ctrl_strobe_t;
endpackage

// File: rtl/trap_entry_win.sv
module trap_entry_win
  import trap_entry_pkg::*;
#(
  parameter int WIN_W = 5
) (
  input  win_op_e          winOp,
  input  logic [WIN_W-1:0] cwpIn,
  input  logic [WIN_W-1:0] cansaveIn,
  input  logic [WIN_W-1:0] nWin,
  output logic [WIN_W-1:0] cwpNext
);
  localparam int EW = WIN_W + 2;

  logic [EW-1:0] nExt, cExt, sExt;
  logic [EW-1:0] cleanVal, fillRaw, fillVal;
  logic [EW-1:0] spillRaw, spillOne, spillTwo;

  assign nExt = EW'(nWin);
  assign cExt = EW'(cwpIn);
  assign sExt = EW'(cansaveIn);

  always_comb begin
    cleanVal = (cExt == '0) ? nExt - EW'(1) : cExt - EW'(1);
    fillRaw  = cExt + EW'(1);
    fillVal  = (fillRaw >= nExt) ? fillRaw - nExt : fillRaw;
    spillRaw = cExt + (nExt << 1) - (sExt + EW'(2));
    spillOne = (spillRaw >= nExt) ? spillRaw - nExt : spillRaw;
    spillTwo = (spillOne >= nExt) ? spillOne - nExt : spillOne;
    unique case (winOp)
      WIN_CLEAN: cwpNext = cleanVal[WIN_W-1:0];
      WIN_SPILL: cwpNext = spillTwo[WIN_W-1:0];
      WIN_FILL:  cwpNext = fillVal[WIN_W-1:0];
      default:   cwpNext = cwpIn;
    endcase
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TL_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [TT_W-1:0] trapType,
  input  logic [TL_W-1:0] maxLevel,
  output ctrl_strobe_t    strobe,
  output logic [TL_W-1:0] newTl,
  output logic [TL_W-1:0] trapLevel,
  output logic            errState,
  output logic            done
);
  logic [TL_W-1:0] levelQ;
  logic            errQ, doneQ;
  logic            atLimit, isMmu, isClean, isSpill, isFill;
  logic [TL_W:0]   nextWide;

  always_comb begin
    atLimit  = levelQ >= maxLevel;
    nextWide = {1'b0, levelQ} + (TL_W+1)'(1);
    isMmu    = (trapType[TT_W-1:4] == 5'h06) && (trapType[3:2] != 2'b00);
    isClean  = trapType == 9'h024;
    isSpill  = (trapType & 9'h1C0) == 9'h080;
    isFill   = (trapType & 9'h1C0) == 9'h0C0;

    strobe.commit = trapReq && !errQ && !atLimit;
    strobe.setRed = nextWide == {1'b0, maxLevel};
    strobe.mmuGrp = isMmu;
    strobe.nested = nextWide > (TL_W+1)'(1);
    if (isClean)      strobe.winOp = WIN_CLEAN;
    else if (isSpill) strobe.winOp = WIN_SPILL;
    else if (isFill)  strobe.winOp = WIN_FILL;
    else              strobe.winOp = WIN_KEEP;
  end

  assign newTl = nextWide[TL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      errQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.commit;
      if (strobe.commit) levelQ <= newTl;
      if (trapReq && !errQ && atLimit) errQ <= 1'b1;
    end
  end

  assign trapLevel = levelQ;
  assign errState  = errQ;
  assign done      = doneQ;
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 12,
  parameter int WIN_W  = 5,
  parameter int DEPTH  = 8,
  localparam int TL_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [TL_W-1:0]   newTl,
  input  logic [TT_W-1:0]   trapType,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] npcIn,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [ADDR_W-1:0] tbaIn,
  input  logic [ADDR_W-1:0] htbaIn,
  input  logic              hyperMode,
  input  logic [WIN_W-1:0]  cwpNext,
  input  logic [TL_W-1:0]   rdIdx,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] npcOut,
  output logic [STAT_W-1:0] statusOut,
  output logic [WIN_W-1:0]  cwpOut,
  output logic [ADDR_W-1:0] rdPc,
  output logic [ADDR_W-1:0] rdNpc,
  output logic [STAT_W-1:0] rdStatus,
  output logic [TT_W-1:0]   rdType
);
  localparam logic [ADDR_W-1:0] T_MASK  = ~ADDR_W'(64'h7FFF);
  localparam logic [ADDR_W-1:0] H_MASK  = ~ADDR_W'(64'h3FFF);
  localparam logic [ADDR_W-1:0] NEST_B  = ADDR_W'(64'h4000);

  logic [ADDR_W-1:0] stkPc     [DEPTH];
  logic [ADDR_W-1:0] stkNpc    [DEPTH];
  logic [STAT_W-1:0] stkStatus [DEPTH];
  logic [TT_W-1:0]   stkType   [DEPTH];

  logic [ADDR_W-1:0] vecOff, vecBase, pcNew;
  logic [STAT_W-1:0] statusNew;

  always_comb begin
    vecOff  = ADDR_W'({trapType, 5'b0});
    vecBase = hyperMode ? (htbaIn & H_MASK)
                        : ((tbaIn & T_MASK) | (strobe.nested ? NEST_B : '0));
    pcNew   = vecBase | vecOff;
    statusNew = '0;
    statusNew[PRIV_B] = 1'b1;
    statusNew[FPEN_B] = 1'b1;
    statusNew[RED_B]  = strobe.setRed;
    if (strobe.mmuGrp) statusNew[MMUG_B] = 1'b1;
    else               statusNew[ALTG_B] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut     <= '0;
      npcOut    <= '0;
      statusOut <= '0;
      cwpOut    <= '0;
    end else if (strobe.commit) begin
      pcOut     <= pcNew;
      npcOut    <= pcNew + ADDR_W'(4);
      statusOut <= statusNew;
      cwpOut    <= cwpNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) begin
      stkPc[newTl]     <= pcIn;
      stkNpc[newTl]    <= npcIn;
      stkStatus[newTl] <= statusIn;
      stkType[newTl]   <= trapType;
    end
  end

  assign rdPc     = stkPc[rdIdx];
  assign rdNpc    = stkNpc[rdIdx];
  assign rdStatus = stkStatus[rdIdx];
  assign rdType   = stkType[rdIdx];
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 12,
  parameter int WIN_W  = 5,
  parameter int DEPTH  = 8,
  localparam int TL_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic [8:0]        trapType,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] npcIn,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [ADDR_W-1:0] tbaIn,
  input  logic [ADDR_W-1:0] htbaIn,
  input  logic [TL_W-1:0]   maxLevel,
  input  logic [WIN_W-1:0]  cwpIn,
  input  logic [WIN_W-1:0]  cansaveIn,
  input  logic [WIN_W-1:0]  nWin,
  input  logic              hyperMode,
  input  logic [TL_W-1:0]   rdIdx,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] npcOut,
  output logic [STAT_W-1:0] statusOut,
  output logic [WIN_W-1:0]  cwpOut,
  output logic [TL_W-1:0]   trapLevel,
  output logic              errState,
  output logic              done,
  output logic [ADDR_W-1:0] rdPc,
  output logic [ADDR_W-1:0] rdNpc,
  output logic [STAT_W-1:0] rdStatus,
  output logic [8:0]        rdType
);
  ctrl_strobe_t    strobe;
  logic [TL_W-1:0] newTl;
  logic [WIN_W-1:0] cwpNext;

  trap_entry_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .maxLevel(maxLevel), .strobe(strobe), .newTl(newTl),
    .trapLevel(trapLevel), .errState(errState), .done(done)
  );

  trap_entry_win #(.WIN_W(WIN_W)) u_win (
    .winOp(strobe.winOp), .cwpIn(cwpIn), .cansaveIn(cansaveIn),
    .nWin(nWin), .cwpNext(cwpNext)
  );

  trap_entry_dp #(
    .ADDR_W(ADDR_W), .STAT_W(STAT_W), .WIN_W(WIN_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newTl(newTl),
    .trapType(trapType), .pcIn(pcIn), .npcIn(npcIn), .statusIn(statusIn),
    .tbaIn(tbaIn), .htbaIn(htbaIn), .hyperMode(hyperMode),
    .cwpNext(cwpNext), .rdIdx(rdIdx), .pcOut(pcOut), .npcOut(npcOut),
    .statusOut(statusOut), .cwpOut(cwpOut), .rdPc(rdPc), .rdNpc(rdNpc),
    .rdStatus(rdStatus), .rdType(rdType)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 12,
  parameter int WIN_W  = 5,
  parameter int TL_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              trapReq,
  input logic [8:0]        trapType,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] npcOut,
  input logic [STAT_W-1:0] statusOut,
  input logic [WIN_W-1:0]  cwpOut,
  input logic [TL_W-1:0]   trapLevel,
  input logic              errState,
  input logic              done
);
  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(trapReq));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(trapReq));

  // R9
  npc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> npcOut == pcOut + ADDR_W'(4));

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errState |=> errState);

  // R2
  err_no_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errState) |-> !done && $stable(pcOut) && $stable(trapLevel));

  // R3
  level_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapLevel != $past(trapLevel)) |-> done && trapLevel == $past(trapLevel) + TL_W'(1));

  // R7
  vec_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pcOut[13:5] == $past(trapType) && pcOut[4:0] == 5'd0);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(statusOut) && $stable(cwpOut) && $stable(npcOut));
endmodule

bind trap_entry_seq trap_entry_chk #(
  .ADDR_W(ADDR_W), .STAT_W(STAT_W), .WIN_W(WIN_W), .TL_W(TL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
  .pcOut(pcOut), .npcOut(npcOut), .statusOut(statusOut), .cwpOut(cwpOut),
  .trapLevel(trapLevel), .errState(errState), .done(done)
);

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
  localparam int ADDR_W = 64;
  localparam int STAT_W = 12;
  localparam int WIN_W  = 5;
  localparam int TL_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 1'b0;
  logic [8:0] trapType = '0;
  logic [ADDR_W-1:0] pcIn = '0, npcIn = '0, tbaIn = '0, htbaIn = '0;
  logic [STAT_W-1:0] statusIn = '0;
  logic [TL_W-1:0] maxLevel = 3'd4, rdIdx = '0;
  logic [WIN_W-1:0] cwpIn = '0, cansaveIn = '0, nWin = 5'd8;
  logic hyperMode = 1'b0;
  logic [ADDR_W-1:0] pcOut, npcOut, rdPc, rdNpc;
  logic [STAT_W-1:0] statusOut, rdStatus;
  logic [WIN_W-1:0] cwpOut;
  logic [TL_W-1:0] trapLevel;
  logic errState, done;
  logic [8:0] rdType;

  int checks = 0;
  int failures = 0;
  int mTl = 0;
  bit mErr = 1'b0;
  int seed = 32'h1d2c;

  always #10 clk = ~clk;

  trap_entry_seq u_trap_entry_seq (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .pcIn(pcIn), .npcIn(npcIn), .statusIn(statusIn), .tbaIn(tbaIn),
    .htbaIn(htbaIn), .maxLevel(maxLevel), .cwpIn(cwpIn),
    .cansaveIn(cansaveIn), .nWin(nWin), .hyperMode(hyperMode),
    .rdIdx(rdIdx), .pcOut(pcOut), .npcOut(npcOut), .statusOut(statusOut),
    .cwpOut(cwpOut), .trapLevel(trapLevel), .errState(errState),
    .done(done), .rdPc(rdPc), .rdNpc(rdNpc), .rdStatus(rdStatus),
    .rdType(rdType)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [STAT_W-1:0] expStatus(input logic [8:0] tt, input bit red);
    logic [STAT_W-1:0] s = '0;
    s[3] = 1'b1;
    s[4] = 1'b1;
    s[5] = red;
    if (tt >= 9'h064 && tt <= 9'h06F) s[1] = 1'b1;
    else s[0] = 1'b1;
    return s;
  endfunction

  function automatic int expCwp(input logic [8:0] tt, input int cwp, input int cs, input int n);
    int v;
    if (tt == 9'h024) v = cwp - 1;
    else if ((tt & 9'h1C0) == 9'h080) v = cwp - cs - 2;
    else if ((tt & 9'h1C0) == 9'h0C0) v = cwp + 1;
    else return cwp;
    return ((v % n) + n) % n;
  endfunction

  function automatic logic [63:0] expPc(input logic [8:0] tt, input bit hyp, input int lvl,
                                        input logic [63:0] tba, input logic [63:0] htba);
    logic [63:0] off = 64'(tt) << 5;
    if (hyp) return (htba & ~64'h3FFF) | off;
    return (tba & ~64'h7FFF) | ((lvl > 1) ? 64'h4000 : 64'h0) | off;
  endfunction

  task automatic doReset(input int maxL);
    @(negedge clk);
    rstN = 1'b0;
    maxLevel = TL_W'(maxL);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mTl = 0;
    mErr = 1'b0;
  endtask

  task automatic doTrap(input logic [8:0] tt, input bit hyp, input int cwp,
                        input int cs, input int n);
    logic [63:0] prevPc, prevNpc, sPc, sNpc, xPc;
    logic [STAT_W-1:0] prevSt, sSt;
    logic [WIN_W-1:0] prevCwp;
    int prevTl;
    bit red;
    prevPc = pcOut; prevNpc = npcOut; prevSt = statusOut; prevCwp = cwpOut;
    prevTl = int'(trapLevel);
    trapType = tt; hyperMode = hyp;
    cwpIn = WIN_W'(cwp); cansaveIn = WIN_W'(cs); nWin = WIN_W'(n);
    sPc = {$urandom(), $urandom()}; sNpc = {$urandom(), $urandom()};
    sSt = STAT_W'($urandom());
    pcIn = sPc; npcIn = sNpc; statusIn = sSt;
    trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0;
    if (mErr || mTl >= int'(maxLevel)) begin
      mErr = 1'b1;
      chk(errState == 1'b1, "R2 errState", 64'(errState), 64'd1);
      chk(done == 1'b0, "R10 no done on reject", 64'(done), 64'd0);
      chk(pcOut == prevPc && npcOut == prevNpc, "R2 pc held", pcOut, prevPc);
      chk(statusOut == prevSt && cwpOut == prevCwp, "R2 status/cwp held",
          64'(statusOut), 64'(prevSt));
      chk(int'(trapLevel) == prevTl, "R2 level held", 64'(trapLevel), 64'(prevTl));
    end else begin
      red = (mTl == int'(maxLevel) - 1);
      mTl++;
      xPc = expPc(tt, hyp, mTl, tbaIn, htbaIn);
      chk(done == 1'b1, "R10 done", 64'(done), 64'd1);
      chk(int'(trapLevel) == mTl, "R3 level", 64'(trapLevel), 64'(mTl));
      chk(statusOut == expStatus(tt, red), "R5/R3 status", 64'(statusOut),
          64'(expStatus(tt, red)));
      chk(int'(cwpOut) == expCwp(tt, cwp, cs, n), "R6 cwp", 64'(cwpOut),
          64'(expCwp(tt, cwp, cs, n)));
      if (hyp) chk(pcOut == xPc, "R8 hyper pc", pcOut, xPc);
      else     chk(pcOut == xPc, "R7 pc", pcOut, xPc);
      chk(npcOut == xPc + 64'd4, "R9 npc", npcOut, xPc + 64'd4);
      rdIdx = TL_W'(mTl);
      #1;
      chk(rdPc == sPc && rdNpc == sNpc, "R4 saved pc", rdPc, sPc);
      chk(rdStatus == sSt && rdType == tt, "R4 saved status/type",
          64'({rdStatus, rdType}), 64'({sSt, tt}));
      @(negedge clk);
      chk(done == 1'b0, "R10 single pulse", 64'(done), 64'd0);
    end
  endtask

  function automatic logic [8:0] pickType();
    int k = $urandom_range(0, 5);
    case (k)
      0: return 9'h024;
      1: return 9'h080 | 9'($urandom_range(0, 63));
      2: return 9'h0C0 | 9'($urandom_range(0, 63));
      3: return 9'h064 | 9'($urandom_range(0, 11));
      default: return 9'($urandom_range(0, 511));
    endcase
  endfunction

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    doReset(3);
    // R1 reset state
    chk(trapLevel == '0 && errState == 1'b0 && done == 1'b0, "R1 ctrl reset",
        64'({trapLevel, errState, done}), 64'd0);
    chk(pcOut == '0 && npcOut == '0 && statusOut == '0 && cwpOut == '0,
        "R1 dp reset", pcOut, 64'd0);

    // directed: wrap corners and bit-14 bases
    tbaIn  = 64'hFFFF_0000_0000_7FFF;
    htbaIn = 64'h1234_5678_0000_7FFF;
    doTrap(9'h024, 1'b0, 0, 0, 8);     // clean wraps to 7, level 1
    doTrap(9'h0C5, 1'b0, 7, 0, 8);     // fill wraps to 0, nested bit
    doTrap(9'h0A0, 1'b1, 1, 7, 8);     // spill 1-9 -> 0, hyper base, red
    doTrap(9'h064, 1'b0, 2, 2, 8);     // reject at limit R2
    doTrap(9'h041, 1'b0, 3, 3, 8);     // still rejected R2

    doReset(1);
    doTrap(9'h06F, 1'b1, 4, 30, 31);   // red on first, MMU group, spill-free
    doTrap(9'h010, 1'b0, 0, 0, 31);

    for (int ep = 0; ep < 40; ep++) begin
      doReset($urandom_range(1, 7));
      tbaIn  = {$urandom(), $urandom()};
      htbaIn = {$urandom(), $urandom()};
      for (int t = 0; t < int'(maxLevel) + 2; t++) begin
        int n = $urandom_range(2, 31);
        doTrap(pickType(), 1'($urandom_range(0, 1)),
               $urandom_range(0, n - 1), $urandom_range(0, n - 1), n);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule